// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital control for a sampling converter. It watches an active-low start request. On a falling edge it raises a busy flag and runs a conversion for a cycle count chosen by the active conversion mode. When the count runs out it loads the result word supplied by the analog core into the output register and drops busy. The falling edge of busy therefore marks new data. Two mode pins select one of four modes: two fast modes with identical timing, a normal mode, and a slow low-power mode. All timing is counted in system clock cycles.

A reset request aborts any conversion in progress. When the request is released, a calibration interval begins and is signalled by holding busy high. A power-down input lets a running conversion finish and then refuses new starts. In the fast modes, the time between conversion starts has an upper limit. If no new start arrives within that limit, a one-cycle fault pulse is raised. All asynchronous inputs pass through a synchroniser before any edge detection.

Top module: `conv_sequencer`

## Requirements
- R1: After reset is released, `busy`, `gap_err` and `result` are all zero.
- R2: A falling edge on `start_n` seen while idle raises `busy`. `busy` then stays high for exactly the mode's conversion length in clock cycles.
- R3: Mode is `{mode_hi, mode_lo}`, sampled when a start is accepted. 2'b11 (wide) and 2'b10 (fast) both use `CONV_FAST`. 2'b00 (normal) uses `CONV_NORMAL`. 2'b01 (low power) uses `CONV_SLOW`.
- R4: `result` takes the value of `core_result` on the clock edge where `busy` falls. At any other time it holds its value.
- R5: A falling edge on `start_n` while `busy` is high is ignored. Holding `start_n` low after a conversion does not start another one.
- R6: While `reset_req` is high, a conversion in progress is aborted. `busy` goes low and `result` is not updated.
- R7: When `reset_req` falls, `busy` goes high for exactly `CAL_CYCLES` cycles and `result` is unchanged.
- R8: When `pwrdn` is high, a running conversion still completes and loads its result. New start edges are ignored while `pwrdn` stays high.
- R9: `gap_err` pulses for exactly one cycle, `MAX_GAP` cycles after `busy` rose for a conversion in mode 2'b11 or 2'b10, if no further start has been accepted by then. It never pulses after a mode 2'b00 or 2'b01 conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| start_n | input | 1 | Active-low conversion request, asynchronous |
| mode_hi | input | 1 | Mode select, upper bit |
| mode_lo | input | 1 | Mode select, lower bit |
| reset_req | input | 1 | Abort and calibrate request, active high, asynchronous |
| pwrdn | input | 1 | Power-down request, active high, asynchronous |
| core_result | input | DATA_W | Conversion value from the analog core |
| busy | output | 1 | Conversion or calibration in progress |
| result | output | DATA_W | Latched conversion result |
| gap_err | output | 1 | One-cycle pulse when the fast-mode gap limit is exceeded |

## Verification
The bench builds the block with short conversion lengths (6, 10 and 16 cycles), a 24-cycle calibration and a gap limit of 150 cycles, replacing the millisecond-scale default. These values keep the three lengths distinct, so a wrong mode decode changes the measured busy width. They also make a gap-limit lapse reachable within a few hundred cycles. Random bursts of conversions stay well inside the gap limit, which checks that no false fault pulses appear. Directed cases cover an abort mid-conversion, power-down mid-conversion, and a retrigger while busy.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'b00,
    CM_SLOW   = 2'b01,
    CM_FAST   = 2'b10,
    CM_WIDE   = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_CAL  = 2'b10
  } seq_state_e;

  function automatic conv_mode_e mode_decode(logic hi, logic lo);
    return conv_mode_e'({hi, lo});
  endfunction

  // Fast and wide modes share timing and the gap limit.
  function automatic logic mode_is_fast(conv_mode_e m);
    return (m == CM_FAST) || (m == CM_WIDE);
  endfunction

  function automatic int unsigned conv_len(conv_mode_e m, int unsigned fast_len,
                                           int unsigned norm_len, int unsigned slow_len);
    int unsigned n;
    case (m)
      CM_FAST, CM_WIDE: n = fast_len;
      CM_SLOW:          n = slow_len;
      default:          n = norm_len;
    endcase
    return n;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cs_fall.sv
module cs_fall #(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic fell
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= IDLE_VAL;
    else        d_q <= d;
  end

  assign fell = d_q & ~d;
endmodule

// File: rtl/cs_gap_mon.sv
module cs_gap_mon #(
  parameter int unsigned MAX_GAP = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic fast,
  input  logic abort,
  output logic armed,
  output logic gap_err
);
  localparam int unsigned GW = $clog2(MAX_GAP + 1);
  localparam logic [GW-1:0] LAST = GW'(MAX_GAP - 1);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      gap_cnt <= '0;
      gap_err <= 1'b0;
    end else begin
      gap_err <= 1'b0;
      if (abort) begin
        armed   <= 1'b0;
        gap_cnt <= '0;
      end else if (accept) begin
        armed   <= fast;
        gap_cnt <= '0;
      end else if (armed) begin
        if (gap_cnt == LAST) begin
          gap_err <= 1'b1;
          armed   <= 1'b0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
  import conv_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_FAST   = 12,
  parameter int unsigned CONV_NORMAL = 20,
  parameter int unsigned CONV_SLOW   = 32,
  parameter int unsigned CAL_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_fall,
  input  logic              rst_hi,
  input  logic              rst_fall,
  input  logic              pd,
  input  conv_mode_e        mode,
  input  logic [DATA_W-1:0] core_result,
  output logic              accept,
  output logic              cal_start,
  output logic              busy,
  output logic [DATA_W-1:0] result
);
  localparam int unsigned MAXLEN = max2(max2(CONV_FAST, CONV_NORMAL), max2(CONV_SLOW, CAL_CYCLES));
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          idle;
  logic          cnt_done;

  assign idle      = (state == ST_IDLE);
  assign cnt_done  = (cnt == '0);
  assign cal_start = idle && rst_fall;
  assign accept    = idle && start_fall && !rst_hi && !rst_fall && !pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      busy   <= 1'b0;
      result <= '0;
    end else if (rst_hi) begin
      state <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cal_start) begin
            state <= ST_CAL;
            busy  <= 1'b1;
            cnt   <= CW'(CAL_CYCLES - 1);
          end else if (accept) begin
            state <= ST_CONV;
            busy  <= 1'b1;
            cnt   <= CW'(conv_len(mode, CONV_FAST, CONV_NORMAL, CONV_SLOW) - 1);
          end
        end
        ST_CONV: begin
          if (cnt_done) begin
            result <= core_result;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CAL: begin
          if (cnt_done) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONV_FAST   = 12,
  parameter int unsigned CONV_NORMAL = 20,
  parameter int unsigned CONV_SLOW   = 32,
  parameter int unsigned CAL_CYCLES  = 64,
  parameter int unsigned MAX_GAP     = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              mode_hi,
  input  logic              mode_lo,
  input  logic              reset_req,
  input  logic              pwrdn,
  input  logic [DATA_W-1:0] core_result,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              gap_err
);
  localparam int unsigned NIN = 5;

  logic [NIN-1:0] raw_in, sync_q;
  logic start_s, rst_s, pd_s, hi_s, lo_s;
  logic start_fall_w, rst_fall_w;
  logic accept_w, cal_start_w, gap_armed_w;
  conv_mode_e mode_now;

  assign raw_in = {start_n, reset_req, pwrdn, mode_hi, mode_lo};
  assign {start_s, rst_s, pd_s, hi_s, lo_s} = sync_q;
  assign mode_now = mode_decode(hi_s, lo_s);

  cs_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(5'b10000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  cs_fall #(.IDLE_VAL(1'b1)) u_start_edge (
    .clk(clk), .rst_n(rst_n), .d(start_s), .fell(start_fall_w)
  );

  cs_fall #(.IDLE_VAL(1'b0)) u_rst_edge (
    .clk(clk), .rst_n(rst_n), .d(rst_s), .fell(rst_fall_w)
  );

  cs_fsm #(
    .DATA_W(DATA_W), .CONV_FAST(CONV_FAST), .CONV_NORMAL(CONV_NORMAL),
    .CONV_SLOW(CONV_SLOW), .CAL_CYCLES(CAL_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_fall(start_fall_w), .rst_hi(rst_s),
    .rst_fall(rst_fall_w), .pd(pd_s), .mode(mode_now), .core_result(core_result),
    .accept(accept_w), .cal_start(cal_start_w), .busy(busy), .result(result)
  );

  cs_gap_mon #(.MAX_GAP(MAX_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .fast(mode_is_fast(mode_now)),
    .abort(rst_s), .armed(gap_armed_w), .gap_err(gap_err)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [DATA_W-1:0] result,
  input logic              gap_err,
  input logic              accept,
  input logic              cal_start,
  input logic              rst_hi,
  input logic              rst_fall,
  input logic              pd,
  input logic              armed
);
  // R2 R7: busy only rises after an accepted start or a calibration start
  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept || cal_start));

  // R4: result moves only together with the falling edge of busy
  assert_result_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  // R6: a synchronised reset request forces busy low on the next cycle
  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hi |=> !busy);

  // R8: no new work starts while powered down
  assert_pd_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && !busy && !rst_fall) |=> !busy);

  // R9: the fault is a single-cycle pulse
  assert_gap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |=> !gap_err);

  // R9: the fault only follows an armed fast-mode window
  assert_gap_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap_err) |-> $past(armed));
endmodule

bind conv_sequencer conv_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .result(result), .gap_err(gap_err),
  .accept(accept_w), .cal_start(cal_start_w), .rst_hi(rst_s), .rst_fall(rst_fall_w),
  .pd(pd_s), .armed(gap_armed_w)
);

// File: tb/conv_sequencer_bench.sv
`timescale 1ns/1ps
module conv_sequencer_bench;
  localparam int DW       = 16;
  localparam int L_FAST   = 6;
  localparam int L_NORM   = 10;
  localparam int L_SLOW   = 16;
  localparam int L_CAL    = 24;
  localparam int GAP      = 150;

  logic clk = 0, rst_n = 0;
  logic start_n = 1, mode_hi = 0, mode_lo = 0, reset_req = 0, pwrdn = 0;
  logic [DW-1:0] core_result = '0;
  logic busy, gap_err;
  logic [DW-1:0] result;

  int checks = 0, fails = 0;
  int cyc = 0, gap_cnt = 0, gap_at = 0, rise_cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  conv_sequencer #(
    .DATA_W(DW), .SYNC_STAGES(2), .CONV_FAST(L_FAST), .CONV_NORMAL(L_NORM),
    .CONV_SLOW(L_SLOW), .CAL_CYCLES(L_CAL), .MAX_GAP(GAP)
  ) u_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .reset_req(reset_req), .pwrdn(pwrdn), .core_result(core_result),
    .busy(busy), .result(result), .gap_err(gap_err)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && gap_err) begin gap_cnt++; gap_at = cyc; end

  function automatic int want_len(bit hi, bit lo);
    if (hi) return L_FAST;
    return lo ? L_SLOW : L_NORM;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // count busy-high samples until busy falls again (or timeout)
  task automatic run_busy(output int n);
    bit seen = 0;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy) begin
        if (!seen) rise_cyc = cyc;
        seen = 1; n++;
      end else if (seen) break;
    end
  endtask

  task automatic count_busy(int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic do_conv(bit hi, bit lo, logic [DW-1:0] data);
    int n, idle_hi;
    @(negedge clk);
    mode_hi = hi; mode_lo = lo; core_result = data;
    repeat (4) @(negedge clk);
    start_n = 0;
    run_busy(n);
    chk(n == want_len(hi, lo), "R2/R3 busy width", n, want_len(hi, lo));
    chk(result == data, "R4 result", int'(result), int'(data));
    count_busy(8, idle_hi);
    chk(idle_hi == 0, "R5 held low no retrigger", idle_hi, 0);
    start_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n, g0;
    logic [DW-1:0] keep;
    void'($urandom(32'h5eed_c0de));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(result == 0, "R1 result", int'(result), 0);
    chk(gap_err == 0, "R1 gap_err", gap_err, 0);

    // each mode once (R3)
    do_conv(1, 1, 16'hA5A5);
    do_conv(1, 0, 16'h0001);
    do_conv(0, 0, 16'hFFFF);
    do_conv(0, 1, 16'h8000);

    // random burst, starts well inside the gap limit
    for (int k = 0; k < 24; k++)
      do_conv(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), DW'($urandom));
    do_conv(0, 0, 16'h1234);  // normal mode clears any fast-mode window
    chk(gap_cnt == 0, "R9 no fault inside limit", gap_cnt, 0);

    // fast-mode gap lapse
    g0 = gap_cnt;
    do_conv(1, 0, 16'h2222);
    g0 = gap_cnt - g0;
    n = rise_cyc;
    repeat (GAP + 40) @(negedge clk);
    chk(gap_cnt == 1, "R9 one pulse after lapse", gap_cnt, 1);
    chk(gap_at - n == GAP, "R9 pulse timing", gap_at - n, GAP);

    // normal/slow conversions never fault
    do_conv(0, 1, 16'h3333);
    repeat (GAP + 40) @(negedge clk);
    chk(gap_cnt == 1, "R9 slow mode no pulse", gap_cnt, 1);

    // retrigger while busy ignored (R5)
    @(negedge clk); mode_hi = 0; mode_lo = 1; core_result = 16'h4444;
    repeat (4) @(negedge clk);
    start_n = 0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy) n++;
      if (i == 6) start_n = 1;
      if (i == 8) start_n = 0;
    end
    chk(n == L_SLOW, "R5 edge during busy ignored", n, L_SLOW);
    start_n = 1; repeat (4) @(negedge clk);

    // power-down mid conversion (R8)
    @(negedge clk); mode_hi = 0; mode_lo = 0; core_result = 16'h5A5A;
    repeat (4) @(negedge clk);
    start_n = 0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy) n++;
      if (i == 3) pwrdn = 1;
    end
    chk(n == L_NORM, "R8 running conversion completes", n, L_NORM);
    chk(result == 16'h5A5A, "R8 result loaded", int'(result), 16'h5A5A);
    start_n = 1; repeat (4) @(negedge clk);
    core_result = 16'h0F0F;
    start_n = 0;
    count_busy(40, n);
    chk(n == 0, "R8 start ignored in power-down", n, 0);
    chk(result == 16'h5A5A, "R8 result kept", int'(result), 16'h5A5A);
    start_n = 1; pwrdn = 0; repeat (6) @(negedge clk);

    // abort then calibration (R6, R7)
    keep = result;
    @(negedge clk); mode_hi = 0; mode_lo = 1; core_result = 16'h7777;
    repeat (4) @(negedge clk);
    start_n = 0;
    repeat (5) @(negedge clk);
    chk(busy == 1, "R6 conversion running", busy, 1);
    reset_req = 1;
    repeat (6) @(negedge clk);
    chk(busy == 0, "R6 busy low on abort", busy, 0);
    repeat (20) @(negedge clk);
    chk(result == keep, "R6 result not updated", int'(result), int'(keep));
    reset_req = 0;
    count_busy(60, n);
    chk(n == L_CAL, "R7 calibration width", n, L_CAL);
    chk(result == keep, "R7 result unchanged", int'(result), int'(keep));
    start_n = 1; repeat (4) @(negedge clk);

    do_conv(1, 1, 16'hBEEF);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule